// File: doc/BRIEF.md
# Debug Mode Entry/Return Controller

This block sequences a small microcontroller between normal program execution (background) and a halted debug state. A breakpoint hit or a host halt request in background saves the current program counter onto the hardware return stack, captures the global interrupt enable, stops the core clock and the timers, and reports a debug status. The host can then ask for a single step, which runs one instruction with the captured interrupt enable in force, or for a return. A return pops the saved address, restores the interrupt enable, redirects the core's fetch to that address and resumes normal execution.

After a return, the breakpoint comparator's match for the first instruction executed is ignored, so that the same breakpoint cannot trap the core again at once. The return stack is shared with the program's own calls. When it is full, a push replaces the oldest entry.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset: status is 00, busy is 0, core_clk_en and timer_en are 1, ie_out is 0, brk_suppress is 0 and stk_level is 0.
- R2: In background, brk_match (when not suppressed) or host_halt_req pushes cpu_pc in the same cycle (stk_push high). From the next cycle on, status is 01 and core_clk_en and timer_en are 0 for as long as status is not 00.
- R3: The status encoding is 00 for background, 01 for halted in debug and 10 for a single step in progress. The value 11 never appears.
- R4: A Trace command (cmd_op 01) accepted while halted gives status 10, busy 1 and core_clk_en 1 on the next cycle, with ie_out equal to the value captured at entry. The cycle after cpu_instr_done, status returns to 01 and busy to 0. While halted, ie_out is 0.
- R5: During a single step, cpu_ie_wr has no effect: ie_out keeps the captured value, and the value restored on return is still the captured one.
- R6: A Return command (cmd_op 10) accepted while halted runs in order. On the next cycle stk_pop and busy are high. On the cycle after that, fetch_load is high with fetch_addr equal to the popped address. On the cycle after that, status is 00, timer_en is 1 and busy is 0.
- R7: After a return, ie_out equals the interrupt enable held at entry. It is 1 only if it was 1 at entry.
- R8: After a return, brk_suppress is 1 and brk_match causes no entry until the first cpu_instr_done in background. After that, brk_match enters debug again.
- R9: The return stack holds DEPTH entries. A push when it is full overwrites the oldest entry, and stk_level stays at DEPTH. Pops return the entries newest first.
- R10: Commands are accepted only while status is 01. cmd_op values 00 and 11, any command in background, and brk_match or host_halt_req while in debug change neither status nor the stack.
- R11: rst_n low while in debug returns the block to background at once (asynchronously): status 00, timer_en 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brk_match | input | 1 | Breakpoint comparator hit for the instruction at cpu_pc |
| host_halt_req | input | 1 | Host request to enter debug |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Command code: 01 trace, 10 return |
| cpu_pc | input | AW | Address of the next instruction |
| cpu_instr_done | input | 1 | Pulse when an instruction completes |
| cpu_ie_wr | input | 1 | Program writes the interrupt enable |
| cpu_ie | input | 1 | Value written by the program |
| cpu_stk_push | input | 1 | Program stack push (call) |
| cpu_stk_pop | input | 1 | Program stack pop (return) |
| cpu_stk_wdata | input | AW | Data for a program push |
| status | output | 2 | Debug status |
| busy | output | 1 | Command sequence in progress |
| core_clk_en | output | 1 | Core clock enable |
| timer_en | output | 1 | Timer enable |
| ie_out | output | 1 | Effective global interrupt enable |
| brk_suppress | output | 1 | Breakpoint suppression active |
| fetch_load | output | 1 | Redirect core fetch to fetch_addr |
| fetch_addr | output | AW | Return address for the fetch |
| stk_push | output | 1 | Stack push strobe |
| stk_pop | output | 1 | Stack pop strobe |
| stk_top | output | AW | Top entry of the stack |
| stk_level | output | $clog2(DEPTH+1) | Number of stack entries |

## Verification
A wrong sequencer state shows up at once at the ports as the wrong status code or the wrong clock and timer enables. A skipped or reordered return step shows up as a missing stk_pop, fetch_load or address within the three cycles after the command. A lost interrupt-enable capture shows up on ie_out in the first trace cycle or in the first background cycle after return. A stuck suppression flag shows up as a breakpoint that is ignored after cpu_instr_done. Stack faults show up as a wrong stk_top or stk_level after the program pushes past capacity and then pops back.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

  typedef enum logic [2:0] {
    ST_BG, ST_HALT, ST_TRACE, ST_RPOP, ST_RFETCH
  } dbg_state_e;

  localparam logic [1:0] STAT_BG    = 2'b00;
  localparam logic [1:0] STAT_HALT  = 2'b01;
  localparam logic [1:0] STAT_TRACE = 2'b10;

  localparam logic [1:0] OP_TRACE  = 2'b01;
  localparam logic [1:0] OP_RETURN = 2'b10;

  // status reported for each sequencer state; it reads 00 only once resumed
  function automatic logic [1:0] status_of(dbg_state_e s);
    case (s)
      ST_BG:    return STAT_BG;
      ST_TRACE: return STAT_TRACE;
      default:  return STAT_HALT;
    endcase
  endfunction

  // stack occupancy after one operation, saturating at the capacity
  function automatic int unsigned next_level(int unsigned lvl, int unsigned cap,
                                             logic push, logic pop);
    if (push) return (lvl >= cap) ? cap : lvl + 1;
    if (pop)  return (lvl == 0) ? 0 : lvl - 1;
    return lvl;
  endfunction

endpackage

// File: rtl/dbg_ret_stack.sv
module dbg_ret_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top,
  output logic [LW-1:0] level
);
  import dbg_mode_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;

  // circular buffer: the write pointer wrapping over the oldest entry is the overwrite
  function automatic logic [PW-1:0] wrap_step(logic [PW-1:0] p, logic up);
    if (up) return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign rptr = wrap_step(wptr, 1'b0);
  assign top  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wptr] <= wdata;
      wptr      <= wrap_step(wptr, 1'b1);
      level     <= LW'(next_level(int'(level), DEPTH, 1'b1, 1'b0));
    end else if (pop && level != '0) begin
      wptr  <= rptr;
      level <= LW'(next_level(int'(level), DEPTH, 1'b0, 1'b1));
    end
  end

  assert_level_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);
  assert_full_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && int'(level) == DEPTH) |=> (int'(level) == DEPTH && top == $past(wdata)));

endmodule

// File: rtl/dbg_ie_keeper.sv
module dbg_ie_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic restore,
  input  logic prog_wr,
  input  logic prog_val,
  input  logic in_bg,
  input  logic in_trace,
  input  logic in_fetch,
  output logic ie_out
);
  logic ie_reg;
  logic ie_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_reg <= 1'b0;
      ie_cap <= 1'b0;
    end else begin
      if (capture)                 ie_cap <= ie_reg;
      if (restore)                 ie_reg <= ie_cap;
      else if (in_bg && !capture && prog_wr) ie_reg <= prog_val;
    end
  end

  // program writes outside background are dropped: the captured value wins
  always_comb begin
    if (in_trace)             ie_out = ie_cap;
    else if (in_bg || in_fetch) ie_out = ie_reg;
    else                      ie_out = 1'b0;
  end

  assert_trace_ie_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_trace && prog_wr) |=> (!in_trace || $stable(ie_out)));

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_evt,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       instr_done,
  output dbg_state_e state,
  output logic       suppress
);
  dbg_state_e nxt;
  logic       take_trace;
  logic       take_ret;

  assign take_trace = (state == ST_HALT) && cmd_valid && (cmd_op == OP_TRACE);
  assign take_ret   = (state == ST_HALT) && cmd_valid && (cmd_op == OP_RETURN);

  always_comb begin
    nxt = state;
    case (state)
      ST_BG:     if (entry_evt) nxt = ST_HALT;
      ST_HALT:   if (take_trace) nxt = ST_TRACE;
                 else if (take_ret) nxt = ST_RPOP;
      ST_TRACE:  if (instr_done) nxt = ST_HALT;
      ST_RPOP:   nxt = ST_RFETCH;
      ST_RFETCH: nxt = ST_BG;
      default:   nxt = ST_BG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_BG;
      suppress <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_RFETCH)                 suppress <= 1'b1;
      else if (state == ST_BG && instr_done)  suppress <= 1'b0;
    end
  end

  assert_ret_pop_then_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RPOP) |=> (state == ST_RFETCH));
  assert_ret_fetch_then_bg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RFETCH) |=> (state == ST_BG && suppress));
  assert_bad_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !take_trace && !take_ret) |=> (state == ST_HALT));

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         brk_match,
  input  logic                         host_halt_req,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [AW-1:0]                cpu_pc,
  input  logic                         cpu_instr_done,
  input  logic                         cpu_ie_wr,
  input  logic                         cpu_ie,
  input  logic                         cpu_stk_push,
  input  logic                         cpu_stk_pop,
  input  logic [AW-1:0]                cpu_stk_wdata,
  output logic [1:0]                   status,
  output logic                         busy,
  output logic                         core_clk_en,
  output logic                         timer_en,
  output logic                         ie_out,
  output logic                         brk_suppress,
  output logic                         fetch_load,
  output logic [AW-1:0]                fetch_addr,
  output logic                         stk_push,
  output logic                         stk_pop,
  output logic [AW-1:0]                stk_top,
  output logic [$clog2(DEPTH+1)-1:0]   stk_level
);
  dbg_state_e state;
  logic       in_bg;
  logic       entry_evt;
  logic       ret_pop_evt;
  logic [AW-1:0] ret_addr;

  assign in_bg       = (state == ST_BG);
  assign entry_evt   = in_bg && (host_halt_req || (brk_match && !brk_suppress));
  assign ret_pop_evt = (state == ST_RPOP);

  dbg_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_evt  (entry_evt),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .instr_done (cpu_instr_done),
    .state      (state),
    .suppress   (brk_suppress)
  );

  dbg_ie_keeper u_ie (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (entry_evt),
    .restore  (ret_pop_evt),
    .prog_wr  (cpu_ie_wr),
    .prog_val (cpu_ie),
    .in_bg    (in_bg),
    .in_trace (state == ST_TRACE),
    .in_fetch (state == ST_RFETCH),
    .ie_out   (ie_out)
  );

  // debug entry owns the stack in its cycle; program ops only run in background
  assign stk_push = entry_evt || (in_bg && cpu_stk_push);
  assign stk_pop  = ret_pop_evt || (in_bg && cpu_stk_pop && !cpu_stk_push);

  dbg_ret_stack #(.DEPTH(DEPTH), .W(AW)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (stk_push),
    .pop   (stk_pop),
    .wdata (entry_evt ? cpu_pc : cpu_stk_wdata),
    .top   (stk_top),
    .level (stk_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ret_addr <= '0;
    else if (ret_pop_evt) ret_addr <= stk_top;
  end

  assign fetch_addr  = ret_addr;
  assign fetch_load  = (state == ST_RFETCH);
  assign status      = status_of(state);
  assign busy        = (state == ST_TRACE) || (state == ST_RPOP) || (state == ST_RFETCH);
  assign core_clk_en = in_bg || (state == ST_TRACE) || (state == ST_RFETCH);
  assign timer_en    = (status == STAT_BG);

  assert_status_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  assert_timer_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status != STAT_BG) |-> !timer_en);
  assert_entry_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bg && host_halt_req) |=> (status == STAT_HALT && !core_clk_en));
  assert_no_rebreak_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bg && brk_suppress && brk_match && !host_halt_req) |=> (status == STAT_BG));
  assert_fetch_matches_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pop_evt |=> (fetch_load && fetch_addr == $past(stk_top)));

endmodule

// File: tb/dbg_mode_ctrl_test.sv
`timescale 1ns/100ps
module dbg_mode_ctrl_test;
  localparam int AW = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_match = 0, host_halt_req = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cpu_pc = 0, cpu_stk_wdata = 0;
  logic cpu_instr_done = 0, cpu_ie_wr = 0, cpu_ie = 0, cpu_stk_push = 0, cpu_stk_pop = 0;
  logic [1:0] status;
  logic busy, core_clk_en, timer_en, ie_out, brk_suppress, fetch_load, stk_push, stk_pop;
  logic [AW-1:0] fetch_addr, stk_top;
  logic [$clog2(DEPTH+1)-1:0] stk_level;

  int n_chk = 0, n_bad = 0, cycles = 0;

  always #2 clk = ~clk;

  dbg_mode_ctrl #(.AW(AW), .DEPTH(DEPTH)) uut (.*);

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_in();
    brk_match = 0; host_halt_req = 0; cmd_valid = 0; cmd_op = 0;
    cpu_instr_done = 0; cpu_ie_wr = 0; cpu_stk_push = 0; cpu_stk_pop = 0;
  endtask

  task automatic send_cmd(logic [1:0] op);
    cmd_valid = 1; cmd_op = op; cyc(); clear_in();
  endtask

  task automatic do_return(logic [AW-1:0] addr, logic ie_exp, int lvl_exp);
    send_cmd(2'b10);
    chk("R6 pop strobe", stk_pop, 1); chk("R6 busy pop", busy, 1);
    chk("R3 status during return", status, 2'b01);
    cyc();
    chk("R6 fetch_load", fetch_load, 1); chk("R6 fetch_addr", fetch_addr, addr);
    chk("R6 busy fetch", busy, 1);
    cyc();
    chk("R6 status 00", status, 2'b00); chk("R6 timer_en", timer_en, 1);
    chk("R6 busy low", busy, 0); chk("R7 ie restored", ie_out, ie_exp);
    chk("R8 suppress set", brk_suppress, 1); chk("R9 level after pop", stk_level, lvl_exp);
  endtask

  task automatic do_trace(logic ie_cap, logic prog_val);
    send_cmd(2'b01);
    chk("R4 status 10", status, 2'b10); chk("R4 busy", busy, 1);
    chk("R4 clk on", core_clk_en, 1); chk("R4 ie captured", ie_out, ie_cap);
    cpu_ie_wr = 1; cpu_ie = prog_val; cyc(); clear_in();
    chk("R5 ie override", ie_out, ie_cap); chk("R4 still tracing", status, 2'b10);
    cpu_instr_done = 1; cyc(); clear_in();
    chk("R4 back to halt", status, 2'b01); chk("R4 busy low", busy, 0);
    chk("R4 clk off", core_clk_en, 0); chk("R4 ie off halted", ie_out, 0);
  endtask

  initial begin
    for (;;) begin
      @(posedge clk); cycles++;
      if (cycles > 5000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    cyc(); cyc();
    chk("R1 status", status, 0); chk("R1 busy", busy, 0); chk("R1 clk", core_clk_en, 1);
    chk("R1 timer", timer_en, 1); chk("R1 ie", ie_out, 0);
    chk("R1 suppress", brk_suppress, 0); chk("R1 level", stk_level, 0);
    rst_n = 1; cyc();

    // R10: command in background ignored
    send_cmd(2'b10);
    chk("R10 bg cmd status", status, 0); chk("R10 bg cmd level", stk_level, 0);
    chk("R10 bg cmd busy", busy, 0);

    cpu_ie_wr = 1; cpu_ie = 1; cyc(); clear_in();
    chk("R7 program ie set", ie_out, 1);

    // R2: breakpoint entry
    brk_match = 1; cpu_pc = 16'h0123; #1;
    chk("R2 push strobe", stk_push, 1);
    cyc(); clear_in();
    chk("R2 status 01", status, 2'b01); chk("R2 timer off", timer_en, 0);
    chk("R2 clk off", core_clk_en, 0); chk("R2 level", stk_level, 1);
    chk("R2 saved pc", stk_top, 16'h0123); chk("R4 ie off halted", ie_out, 0);

    // R10: bad opcodes and triggers in debug ignored
    send_cmd(2'b00); chk("R10 op00", status, 2'b01);
    send_cmd(2'b11); chk("R10 op11", status, 2'b01); chk("R10 op11 busy", busy, 0);
    brk_match = 1; host_halt_req = 1; cyc(); clear_in();
    chk("R10 trigger in debug level", stk_level, 1); chk("R10 trigger status", status, 2'b01);

    do_trace(1'b1, 1'b0);
    do_return(16'h0123, 1'b1, 0);

    // R8: first instruction after return does not break
    brk_match = 1; cpu_pc = 16'h0200; cyc(); clear_in();
    chk("R8 no rebreak", status, 0); chk("R8 no push", stk_level, 0);
    cpu_instr_done = 1; cyc(); clear_in();
    chk("R8 suppress cleared", brk_suppress, 0);
    cpu_ie_wr = 1; cpu_ie = 0; cyc(); clear_in();
    chk("R7 program ie clear", ie_out, 0);
    brk_match = 1; cpu_pc = 16'h0204; cyc(); clear_in();
    chk("R8 breaks after first instr", status, 2'b01);
    chk("R2 second saved pc", stk_top, 16'h0204);

    do_trace(1'b0, 1'b1);
    do_return(16'h0204, 1'b0, 0);
    cpu_instr_done = 1; cyc(); clear_in();

    // R9: stack fill and overwrite
    for (int i = 0; i < DEPTH; i++) begin
      cpu_stk_push = 1; cpu_stk_wdata = AW'(16'h0010 + i); cyc(); clear_in();
    end
    chk("R9 full level", stk_level, DEPTH);
    host_halt_req = 1; cpu_pc = 16'h0055; cyc(); clear_in();
    chk("R9 level capped", stk_level, DEPTH); chk("R9 top is pc", stk_top, 16'h0055);
    do_return(16'h0055, 1'b0, DEPTH - 1);
    chk("R9 newest first", stk_top, 16'h0010 + DEPTH - 1);
    for (int i = 0; i < DEPTH - 2; i++) begin
      cpu_stk_pop = 1; cyc(); clear_in();
      chk("R9 pop order", stk_top, 16'h0010 + DEPTH - 2 - i);
    end
    chk("R9 oldest lost level", stk_level, 1);
    chk("R9 oldest lost top", stk_top, 16'h0011);

    // R11: reset in debug
    host_halt_req = 1; cyc(); clear_in();
    chk("R11 in debug", status, 2'b01);
    #1 rst_n = 0; #1;
    chk("R11 async status", status, 0); chk("R11 timer", timer_en, 1);
    cyc(); rst_n = 1; cyc();
    chk("R11 stays bg", status, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule